// File: doc/BRIEF.md
# Six-Digit BCD Event Counter

This block counts rising edges on an asynchronous pulse input and keeps the total as six packed BCD digits, from 000000 to 999999. A host reaches every register through a simple synchronous register port: one write strobe, a 4-bit address, write data, and read data that is decoded combinationally from the address. Counting happens only while the mode field of the control register selects event counting.

Three alarm bytes hold a six-digit reference value. When the alarm type field arms the event alarm and the count equals that reference, a sticky alarm flag is set. Software clears the flag. The flag drives an active-low interrupt output when the interrupt enable bit is set. A two-digit BCD timer advances once for every 1, 100, 10,000 or 1,000,000 counted events, chosen by a prescale code.

Top module: `bcd_event_counter`

## Requirements
- R1: After reset every register reads 8'h00 and `intN` is high.
- R2: Edges are counted only while control bits [5:4] equal 2'b10. For any other value, pulses leave the count unchanged.
- R3: The input passes through a two-flop synchroniser. Each rising edge then adds exactly one to the count, however long the input stays high. The new count can be read three clock edges after the input rises.
- R4: The count is read at address 1 (digits 1 and 0), address 2 (digits 3 and 2) and address 3 (digits 5 and 4). In each byte the lower digit sits in bits [3:0]. After 999999 the count wraps to 000000.
- R5: A write to address 1, 2 or 3 presets that count byte. If a detected edge falls in the same cycle as such a write, the edge is dropped and the timer does not advance.
- R6: Control bit 1 is the alarm flag. It is set one cycle after a cycle in which all three of the following hold: the block is in event mode, alarm control bits [5:4] equal 2'b01, and the count equals the reference at addresses 6, 7 and 8 (which use the same digit layout as the count). Writing the control register loads bit 1 from the write data, but a match in the same cycle keeps the flag set.
- R7: `intN` is low exactly when the alarm flag is set and alarm control bit 7 is set.
- R8: The timer at address 4 holds two BCD digits and wraps from 99 to 00. A write presets it. Alarm control bits [2:0] choose when it advances: code 0 means on every counted event; code 1 when the low two count digits roll over to 00; code 2 when the low four digits roll over; code 3 when all six digits roll over; codes 4 to 7 mean on every event.
- R9: Address 0 is control, address 5 is alarm control, and addresses 9 to 15 read 8'h00. Writes to addresses 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eventIn | input | 1 | Asynchronous pulse input to be counted |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Read data for `addr` |
| intN | output | 1 | Active-low alarm interrupt |

## Verification
The hardest situation to reach from the ports is a synchronised edge that lands in exactly the cycle of a count write. The stimulus raises `eventIn` and then asserts the write strobe two clock edges later, so that the write lines up with the edge detector's output. The prescale rollovers at 10,000 and 1,000,000 events are also too long to reach by counting pulses. The bench presets the count to just below each boundary through the count registers and then sends one pulse. A behavioural reference model, built on integer arithmetic, is compared on every clock against the read data for the current address and against `intN`.

// File: rtl/bcd_evc_pkg.sv
package bcd_evc_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int NUM_PAIRS = 3;
  localparam int NUM_DIGS  = 2 * NUM_PAIRS;
  localparam int CNT_W     = 4 * NUM_DIGS;

  localparam int ADR_CTRL = 0;
  localparam int ADR_CNT0 = 1;
  localparam int ADR_TMR  = 4;
  localparam int ADR_ACTL = 5;
  localparam int ADR_ALM0 = 6;

  localparam logic [1:0] MODE_EVENT = 2'b10;
  localparam logic [1:0] ALM_EVENT  = 2'b01;

  typedef struct packed {
    logic                 countEn;
    logic [NUM_PAIRS-1:0] cntWr;
    logic                 tmrWr;
    logic [NUM_PAIRS-1:0] almWr;
  } evcStrobe_t;
endpackage

// File: rtl/bcd_evc_ctrl.sv
module bcd_evc_ctrl
  import bcd_evc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eventIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              matchRaw,
  output evcStrobe_t        strb,
  output logic [DATA_W-1:0] statusRd,
  output logic [DATA_W-1:0] actlRd,
  output logic              intN
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   rise;
  logic [DATA_W-1:0]      ctrlQ;
  logic [DATA_W-1:0]      actlQ;
  logic                   flagQ;
  logic                   eventMode;
  logic                   armed;
  logic                   anyCntWr;
  logic                   ctrlWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], eventIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rise      = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign eventMode = (ctrlQ[5:4] == MODE_EVENT);
  assign armed     = eventMode && (actlQ[5:4] == ALM_EVENT);
  assign ctrlWr    = wrEn && (int'(addr) == ADR_CTRL);
  assign anyCntWr  = |strb.cntWr;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gDec
    assign strb.cntWr[p] = wrEn && (int'(addr) == ADR_CNT0 + p);
    assign strb.almWr[p] = wrEn && (int'(addr) == ADR_ALM0 + p);
  end

  assign strb.tmrWr   = wrEn && (int'(addr) == ADR_TMR);
  assign strb.countEn = rise && eventMode && !anyCntWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      actlQ <= '0;
      flagQ <= 1'b0;
    end else begin
      if (ctrlWr) ctrlQ <= wrData;
      if (wrEn && (int'(addr) == ADR_ACTL)) actlQ <= wrData;
      flagQ <= (armed && matchRaw) || (ctrlWr ? wrData[1] : flagQ);
    end
  end

  assign statusRd = {ctrlQ[7:2], flagQ, ctrlQ[0]};
  assign actlRd   = actlQ;
  assign intN     = ~(flagQ & actlQ[7]);
endmodule

// File: rtl/bcd_evc_datapath.sv
module bcd_evc_datapath
  import bcd_evc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  evcStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        tmrSel,
  output logic [CNT_W-1:0]  countQ,
  output logic [CNT_W-1:0]  almQ,
  output logic [DATA_W-1:0] timerQ,
  output logic              matchRaw
);
  logic [NUM_DIGS:0] carry;
  logic              tick;
  logic [3:0]        tLo, tHi;

  assign carry[0] = strb.countEn;

  for (genvar i = 0; i < NUM_DIGS; i++) begin : gDig
    localparam int P = i / 2;
    localparam int H = i % 2;
    logic [3:0] dQ;
    assign carry[i+1] = carry[i] && (dQ == 4'd9);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               dQ <= '0;
      else if (strb.cntWr[P])  dQ <= wrData[4*H +: 4];
      else if (carry[i])       dQ <= (dQ == 4'd9) ? 4'd0 : dQ + 4'd1;
    end
    assign countQ[4*i +: 4] = dQ;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gAlm
    logic [7:0] aQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              aQ <= '0;
      else if (strb.almWr[p]) aQ <= wrData;
    end
    assign almQ[8*p +: 8] = aQ;
  end

  assign matchRaw = (countQ == almQ);

  always_comb begin
    tick = carry[0];
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (int'(tmrSel) == p + 1) tick = carry[2*p+2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tLo <= '0;
      tHi <= '0;
    end else if (strb.tmrWr) begin
      tLo <= wrData[3:0];
      tHi <= wrData[7:4];
    end else if (tick) begin
      if (tLo == 4'd9) begin
        tLo <= 4'd0;
        tHi <= (tHi == 4'd9) ? 4'd0 : tHi + 4'd1;
      end else begin
        tLo <= tLo + 4'd1;
      end
    end
  end

  assign timerQ = {tHi, tLo};
endmodule

// File: rtl/bcd_event_counter.sv
module bcd_event_counter
  import bcd_evc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              eventIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              intN
);
  evcStrobe_t        strb;
  logic [DATA_W-1:0] statusRd;
  logic [DATA_W-1:0] actlRd;
  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  almQ;
  logic [DATA_W-1:0] timerQ;
  logic              matchRaw;

  bcd_evc_ctrl #(.SYNC_STAGES(2)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .eventIn  (eventIn),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .matchRaw (matchRaw),
    .strb     (strb),
    .statusRd (statusRd),
    .actlRd   (actlRd),
    .intN     (intN)
  );

  bcd_evc_datapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .tmrSel   (actlRd[2:0]),
    .countQ   (countQ),
    .almQ     (almQ),
    .timerQ   (timerQ),
    .matchRaw (matchRaw)
  );

  always_comb begin
    rdData = '0;
    if (int'(addr) == ADR_CTRL) rdData = statusRd;
    if (int'(addr) == ADR_TMR)  rdData = timerQ;
    if (int'(addr) == ADR_ACTL) rdData = actlRd;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (int'(addr) == ADR_CNT0 + p) rdData = countQ[8*p +: 8];
      if (int'(addr) == ADR_ALM0 + p) rdData = almQ[8*p +: 8];
    end
  end
endmodule

// File: rtl/bcd_event_counter_chk.sv
module bcd_event_counter_chk
  import bcd_evc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              intN,
  input logic [CNT_W-1:0]  countQ,
  input logic [DATA_W-1:0] statusRd,
  input logic [DATA_W-1:0] actlRd,
  input logic              matchRaw
);
  logic cntWrAny;
  logic armedNow;
  assign cntWrAny = wrEn && (int'(addr) >= ADR_CNT0) && (int'(addr) < ADR_CNT0 + NUM_PAIRS);
  assign armedNow = (statusRd[5:4] == MODE_EVENT) && (actlRd[5:4] == ALM_EVENT);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd[5:4] != MODE_EVENT && !cntWrAny) |=> (countQ == $past(countQ))); // R2

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cntWrAny) && countQ != $past(countQ)) |->
      (countQ[3:0] == (($past(countQ[3:0]) == 4'd9) ? 4'd0 : $past(countQ[3:0]) + 4'd1))); // R3

  AST_PRESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) == ADR_CNT0) |=> (countQ[7:0] == $past(wrData))); // R5

  AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (armedNow && matchRaw) |=> statusRd[1]); // R6

  AST_INT_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !actlRd[7] |-> intN); // R7
endmodule

bind bcd_event_counter bcd_event_counter_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .intN     (intN),
  .countQ   (countQ),
  .statusRd (statusRd),
  .actlRd   (actlRd),
  .matchRaw (matchRaw)
);

// File: tb/bcd_event_counter_test.sv
`timescale 1ns/1ps
module bcd_event_counter_test;
  logic       clk = 0;
  logic       rstN = 0;
  logic       eventIn = 0;
  logic       wrEn = 0;
  logic [3:0] addr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic       intN;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  int mCnt = 0, mTmr = 0, mAlm = 0, mCtrl = 0, mActl = 0;
  bit mFlag = 0, s0 = 0, s1 = 0, prv = 0;

  bcd_event_counter uut (.clk(clk), .rstN(rstN), .eventIn(eventIn), .wrEn(wrEn),
                         .addr(addr), .wrData(wrData), .rdData(rdData), .intN(intN));

  always #5 clk = ~clk;

  function automatic int fromBcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] toBcd(input int v);
    logic [3:0] hi, lo;
    hi = 4'((v / 10) % 10);
    lo = 4'(v % 10);
    return {hi, lo};
  endfunction

  function automatic int putByte(input int val, input int idx, input logic [7:0] b);
    int w = 1;
    for (int k = 0; k < idx; k++) w = w * 100;
    return val - ((val / w) % 100) * w + fromBcd(b) * w;
  endfunction

  function automatic logic [7:0] expRd(input int a);
    case (a)
      0: return 8'(mCtrl & 8'hFD) | (mFlag ? 8'h02 : 8'h00);
      1: return toBcd(mCnt % 100);
      2: return toBcd((mCnt / 100) % 100);
      3: return toBcd(mCnt / 10000);
      4: return toBcd(mTmr);
      5: return 8'(mActl);
      6: return toBcd(mAlm % 100);
      7: return toBcd((mAlm / 100) % 100);
      8: return toBcd(mAlm / 10000);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string reqOf(input int a);
    case (a)
      0, 6, 7, 8: return "R6";
      1, 2, 3:    return "R4";
      4:          return "R8";
      default:    return "R9";
    endcase
  endfunction

  // reference model, advanced on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mTmr = 0; mAlm = 0; mCtrl = 0; mActl = 0;
      mFlag = 0; s0 = 0; s1 = 0; prv = 0;
    end else begin
      bit rise, em, cw, inc, match, tick, wr0;
      int a, sel;
      a     = int'(addr);
      rise  = s1 && !prv;
      em    = ((mCtrl >> 4) & 3) == 2;
      cw    = wrEn && a >= 1 && a <= 3;
      inc   = rise && em && !cw;
      match = em && (((mActl >> 4) & 3) == 1) && (mCnt == mAlm);
      wr0   = wrEn && a == 0;
      sel   = mActl & 7;
      tick  = 0;
      if (inc) begin
        case (sel)
          1: tick = (mCnt % 100) == 99;
          2: tick = (mCnt % 10000) == 9999;
          3: tick = mCnt == 999999;
          default: tick = 1;
        endcase
      end
      mFlag = match || (wr0 ? wrData[1] : mFlag);
      if (inc) mCnt = (mCnt + 1) % 1000000;
      if (cw) mCnt = putByte(mCnt, a - 1, wrData);
      if (wrEn && a == 4) mTmr = fromBcd(wrData);
      else if (tick) mTmr = (mTmr + 1) % 100;
      if (wr0) mCtrl = int'(wrData);
      if (wrEn && a == 5) mActl = int'(wrData);
      if (wrEn && a >= 6 && a <= 8) mAlm = putByte(mAlm, a - 6, wrData);
      prv = s1; s1 = s0; s0 = eventIn;
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rstN && !finished) begin
      tests++;
      if (rdData !== expRd(int'(addr))) begin
        fails++;
        $display("FAIL %s: addr %0d got %h expected %h", reqOf(int'(addr)), addr, rdData, expRd(int'(addr)));
      end
      tests++;
      if (intN !== !(mFlag && mActl[7])) begin
        fails++;
        $display("FAIL R7: intN got %b expected %b", intN, !(mFlag && mActl[7]));
      end
    end
  end

  task automatic chkVal(input int a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = 4'(a);
    #1;
    tests++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: addr %0d got %h expected %h", req, a, rdData, exp);
    end
  endtask

  task automatic chkInt(input logic exp, input string req);
    @(negedge clk);
    tests++;
    if (intN !== exp) begin
      fails++;
      $display("FAIL %s: intN got %b expected %b", req, intN, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1; addr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) eventIn = 1;
      repeat (3) @(negedge clk);
      eventIn = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic presetCount(input logic [7:0] b3, input logic [7:0] b2, input logic [7:0] b1);
    wr(1, b1); wr(2, b2); wr(3, b3);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    for (int a = 0; a < 9; a++) chkVal(a, 8'h00, "R1");
    chkInt(1'b1, "R1");

    // R2: not in event mode, pulses ignored
    pulse(3);
    chkVal(1, 8'h00, "R2");

    // R3: event mode, one count per edge, long high counts once
    wr(0, 8'h20);
    pulse(5);
    chkVal(1, 8'h05, "R3");
    @(negedge clk) eventIn = 1;
    repeat (12) @(negedge clk);
    eventIn = 0;
    repeat (3) @(negedge clk);
    chkVal(1, 8'h06, "R3");

    // R4: wrap from 999999
    presetCount(8'h99, 8'h99, 8'h98);
    pulse(2);
    chkVal(1, 8'h00, "R4");
    chkVal(2, 8'h00, "R4");
    chkVal(3, 8'h00, "R4");
    chkVal(4, 8'h08, "R8");

    // R8: prescale codes
    wr(5, 8'h01);
    presetCount(8'h00, 8'h00, 8'h99);
    pulse(1);
    chkVal(2, 8'h01, "R4");
    chkVal(4, 8'h09, "R8");
    pulse(1);
    chkVal(4, 8'h09, "R8");
    wr(5, 8'h02);
    presetCount(8'h00, 8'h99, 8'h99);
    pulse(1);
    chkVal(4, 8'h10, "R8");
    wr(5, 8'h03);
    presetCount(8'h99, 8'h99, 8'h99);
    pulse(1);
    chkVal(4, 8'h11, "R8");
    pulse(1);
    chkVal(4, 8'h11, "R8");
    wr(5, 8'h06);
    wr(4, 8'h99);
    pulse(1);
    chkVal(4, 8'h00, "R8");

    // R5: write collides with a detected edge
    wr(5, 8'h00);
    presetCount(8'h00, 8'h00, 8'h10);
    @(negedge clk) eventIn = 1;
    @(negedge clk);
    @(negedge clk) begin wrEn = 1; addr = 4'd1; wrData = 8'h42; end
    @(negedge clk) begin wrEn = 0; eventIn = 0; end
    repeat (4) @(negedge clk);
    chkVal(1, 8'h42, "R5");
    chkVal(4, 8'h00, "R5");

    // R6 / R7: alarm match, interrupt, clearing
    wr(6, 8'h45); wr(7, 8'h00); wr(8, 8'h00);
    wr(5, 8'h90);
    pulse(3);
    chkVal(0, 8'h22, "R6");
    chkInt(1'b0, "R7");
    pulse(1);
    wr(0, 8'h20);
    chkVal(0, 8'h20, "R6");
    chkInt(1'b1, "R7");
    wr(1, 8'h45);
    repeat (2) @(negedge clk);
    wr(0, 8'h20);
    chkVal(0, 8'h22, "R6");
    wr(5, 8'h10);
    chkInt(1'b1, "R7");
    chkVal(0, 8'h22, "R6");
    wr(5, 8'h20);
    wr(0, 8'h20);
    repeat (2) @(negedge clk);
    chkVal(0, 8'h20, "R6");

    // R9: unused addresses
    wr(12, 8'hFF);
    wr(9, 8'h5A);
    chkVal(12, 8'h00, "R9");
    chkVal(9, 8'h00, "R9");
    chkVal(1, 8'h45, "R9");

    // R2: leaving event mode freezes the count
    wr(0, 8'h00);
    pulse(2);
    chkVal(1, 8'h45, "R2");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule